// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Array

This block decides whether a received CAN frame header is wanted. It holds a set of programmable filter banks that all work in mask mode. A per-bank scale bit makes a bank either one wide filter, which compares a 32-bit header word, or two narrow filters, which compare 16-bit header words. When the receive path presents a header strobe carrying the identifier, the IDE flag and the RTR flag, the block reports one clock later whether the frame passes. If it passes, the block also reports the match index of the winning filter.

Bank contents, the scale vector and the active vector are loaded through a simple register write port. That port takes effect only while the configuration-mode input is high. Match indices are counted across the whole array, so the receive path can use them to route a frame. All wide filters are numbered first, in bank order. The narrow filters follow, two per bank.

Top module: `can_acc_filter`

## Requirements
- R1: After reset all outputs are low, every bank word is zero, every bank is inactive and in 16-bit scale, and any header is rejected.
- R2: `res_valid` is high for exactly the cycle after a cycle with `hdr_valid` high. `res_accept` and `res_index` are updated only on that edge and hold their value otherwise.
- R3: Write address 2b loads bank b word 1 and address 2b+1 loads bank b word 2. Address 2N loads the scale vector, where bit b = 1 selects 32-bit scale. Address 2N+1 loads the active vector. A write has no effect while `cfg_init` is low.
- R4: In 32-bit scale, word 1 is the filter ID and word 2 is the mask, and a mask bit of 1 forces that bit to match. For an extended frame the header word is ID[28:0] at bits 31:3, IDE at bit 2 and RTR at bit 1, with bit 0 zero. For a standard frame the 11-bit ID sits at bits 31:21, IDE and bits 20:3 are zero, and RTR is at bit 1.
- R5: In 16-bit scale, each word holds the ID in bits 15:0 and the mask in bits 31:16. Word 1 is the even (first) filter and word 2 the odd one. The header half-word puts the 11-bit ID at bits 15:5, RTR at bit 4 and IDE at bit 3. Bits 2:0 are zero for standard frames and carry ID[17:15] for extended frames, whose bits 15:5 then carry ID[28:18].
- R6: A bank whose active bit is clear never matches, but its filters still take up their match indices.
- R7: A filter with ID zero and an all-ones mask rejects every frame, in either scale.
- R8: Wide filters take indices 0 to W-1 in ascending bank order. Narrow filters follow from index W, two per 16-bit bank in ascending bank order, with word 1 before word 2.
- R9: When several filters match, the lowest index is reported. A rejected header reports index 0.
- R10: A mask bit of 0 is a don't-care. A mask with only the IDE bit set accepts every identifier of the filter's frame type, and a clear RTR mask bit accepts both data and remote frames.

Top module ports (N = `NUM_BANKS`, default 14):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_init | input | 1 | Configuration mode; writes are honoured only while high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (5) | Register write address |
| cfg_wdata | input | 32 | Register write data |
| hdr_valid | input | 1 | Header strobe |
| hdr_id | input | 29 | Frame identifier; standard frames use bits 10:0 |
| hdr_ide | input | 1 | 1 = extended frame |
| hdr_rtr | input | 1 | 1 = remote frame |
| res_valid | output | 1 | Result strobe, one cycle after `hdr_valid` |
| res_accept | output | 1 | Header passed at least one active filter |
| res_index | output | IDX_W (5) | Match index of the winning filter |

## Verification
The bench sets up a mix of 32-bit and 16-bit banks in which several filters match the same frame. A priority encoder that scanned the banks in plain bank order, rather than wide filters first, would then report the wrong index. Inactive banks sit between active ones, so a numbering that skipped inactive banks would shift every later index. The bench programs ID-zero, all-ones-mask filters in both scales with a header that would otherwise match them, so a design without the closing rule would accept. The bench also writes registers with `cfg_init` low and checks that the match behaviour is unchanged. It checks that results hold between strobes, and it sends an extended frame into a 16-bit filter so that the bits 2:0 mapping is exercised.

// File: rtl/can_flt_pkg.sv
// Shared header type and header-word builders for the acceptance filter array.
// Assumes a 29-bit identifier field; standard frames carry their ID in bits 10:0.
package can_flt_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned ID_W   = 29;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            ide;
        logic            rtr;
    } can_hdr_t;

    // Header laid out as a 32-bit comparison word
    function automatic logic [WORD_W-1:0] wide_word(can_hdr_t h);
        if (h.ide)
            return {h.id, 1'b1, h.rtr, 1'b0};
        else
            return {h.id[10:0], 18'd0, 1'b0, h.rtr, 1'b0};
    endfunction

    // Header laid out as a 16-bit comparison half-word
    function automatic logic [HALF_W-1:0] narrow_word(can_hdr_t h);
        if (h.ide)
            return {h.id[28:18], h.rtr, 1'b1, h.id[17:15]};
        else
            return {h.id[10:0], h.rtr, 1'b0, 3'b000};
    endfunction

endpackage

// File: rtl/can_flt_regs.sv
// Configuration storage: two words per bank plus scale and active vectors.
// Assumes NUM_BANKS <= 32 so each vector fits one write word. Writes land
// only while cfg_init is high.
module can_flt_regs #(
    parameter int unsigned NUM_BANKS = 14,
    parameter int unsigned ADDR_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_init,
    input  logic                          cfg_we,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    output logic [NUM_BANKS-1:0][31:0]    word1,
    output logic [NUM_BANKS-1:0][31:0]    word2,
    output logic [NUM_BANKS-1:0]          scale,
    output logic [NUM_BANKS-1:0]          active
);

    localparam int unsigned SCALE_ADDR  = 2 * NUM_BANKS;
    localparam int unsigned ACTIVE_ADDR = 2 * NUM_BANKS + 1;

    logic wr_ok;
    assign wr_ok = cfg_init && cfg_we;

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            // Load this bank's two filter words
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word1[b] <= '0;
                    word2[b] <= '0;
                end else if (wr_ok) begin
                    if (cfg_addr == ADDR_W'(2 * b))
                        word1[b] <= cfg_wdata;
                    if (cfg_addr == ADDR_W'(2 * b + 1))
                        word2[b] <= cfg_wdata;
                end
            end
        end
    endgenerate

    // Load the scale and active vectors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale  <= '0;
            active <= '0;
        end else if (wr_ok) begin
            if (cfg_addr == ADDR_W'(SCALE_ADDR))
                scale <= cfg_wdata[NUM_BANKS-1:0];
            if (cfg_addr == ADDR_W'(ACTIVE_ADDR))
                active <= cfg_wdata[NUM_BANKS-1:0];
        end
    end

    // R3
    no_cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_init |=> ($stable(word1) && $stable(word2) && $stable(scale) && $stable(active)));

endmodule

// File: rtl/can_flt_bank.sv
// One filter bank in mask mode: either one wide compare or two narrow compares.
// Assumes word layouts from can_flt_pkg; an ID-zero, all-ones-mask filter is closed.
module can_flt_bank
    import can_flt_pkg::*;
(
    input  can_hdr_t     hdr,
    input  logic [31:0]  word1,
    input  logic [31:0]  word2,
    input  logic         wide,
    input  logic         enable,
    output logic         hit_wide,
    output logic         hit_lo,
    output logic         hit_hi
);

    logic [WORD_W-1:0] hw;
    logic [HALF_W-1:0] hn;
    logic wide_open, lo_open, hi_open;

    // Build the header comparison words
    always_comb begin
        hw = wide_word(hdr);
        hn = narrow_word(hdr);
    end

    // A filter is open unless it is the ID-zero, all-ones-mask pattern
    always_comb begin
        wide_open = !((word1 == '0) && (word2 == '1));
        lo_open   = !((word1[15:0] == '0) && (word1[31:16] == '1));
        hi_open   = !((word2[15:0] == '0) && (word2[31:16] == '1));
    end

    // Masked compares, gated by scale and active bit
    always_comb begin
        hit_wide = enable && wide && wide_open
                   && (((hw ^ word1) & word2) == '0);
        hit_lo   = enable && !wide && lo_open
                   && (((hn ^ word1[15:0]) & word1[31:16]) == '0);
        hit_hi   = enable && !wide && hi_open
                   && (((hn ^ word2[15:0]) & word2[31:16]) == '0);
    end

endmodule

// File: rtl/can_flt_prio.sv
// Numbers every filter (wide first, then narrow pairs) and picks the lowest
// matching index. Inactive banks still take their index slots.
module can_flt_prio #(
    parameter int unsigned NUM_BANKS = 14,
    parameter int unsigned IDX_W     = 5
) (
    input  logic [NUM_BANKS-1:0] scale,
    input  logic [NUM_BANKS-1:0] hit_wide,
    input  logic [NUM_BANKS-1:0] hit_lo,
    input  logic [NUM_BANKS-1:0] hit_hi,
    output logic                 any_hit,
    output logic [IDX_W-1:0]     win_idx
);

    localparam int unsigned CNT_W = IDX_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] pick;

    // Scan wide filters, then narrow filters, keeping the first hit
    always_comb begin
        any_hit = 1'b0;
        pick    = '0;
        cnt     = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (scale[b]) begin
                if (hit_wide[b] && !any_hit) begin
                    any_hit = 1'b1;
                    pick    = cnt;
                end
                cnt = cnt + CNT_W'(1);
            end
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (!scale[b]) begin
                if (hit_lo[b] && !any_hit) begin
                    any_hit = 1'b1;
                    pick    = cnt;
                end else if (hit_hi[b] && !any_hit) begin
                    any_hit = 1'b1;
                    pick    = cnt + CNT_W'(1);
                end
                cnt = cnt + CNT_W'(2);
            end
        end
        win_idx = pick[IDX_W-1:0];
    end

endmodule

// File: rtl/can_acc_filter.sv
// Top of the acceptance filter array: config registers, per-bank compares,
// index priority and a registered result stage one cycle after the strobe.
// Assumes hdr_* are stable in the cycle hdr_valid is high.
module can_acc_filter
    import can_flt_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 14,
    parameter int unsigned NFILT     = 2 * NUM_BANKS,
    parameter int unsigned IDX_W     = $clog2(NFILT),
    parameter int unsigned ADDR_W    = $clog2(2 * NUM_BANKS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_init,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              hdr_valid,
    input  logic [28:0]       hdr_id,
    input  logic              hdr_ide,
    input  logic              hdr_rtr,
    output logic              res_valid,
    output logic              res_accept,
    output logic [IDX_W-1:0]  res_index
);

    logic [NUM_BANKS-1:0][31:0] word1;
    logic [NUM_BANKS-1:0][31:0] word2;
    logic [NUM_BANKS-1:0]       scale;
    logic [NUM_BANKS-1:0]       active;
    logic [NUM_BANKS-1:0]       hit_wide, hit_lo, hit_hi;
    logic                       any_hit;
    logic [IDX_W-1:0]           win_idx;
    can_hdr_t                   hdr;

    assign hdr = '{id: hdr_id, ide: hdr_ide, rtr: hdr_rtr};

    can_flt_regs #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_init  (cfg_init),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .word1     (word1),
        .word2     (word2),
        .scale     (scale),
        .active    (active)
    );

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_cmp
            can_flt_bank u_bank (
                .hdr      (hdr),
                .word1    (word1[b]),
                .word2    (word2[b]),
                .wide     (scale[b]),
                .enable   (active[b]),
                .hit_wide (hit_wide[b]),
                .hit_lo   (hit_lo[b]),
                .hit_hi   (hit_hi[b])
            );
        end
    endgenerate

    can_flt_prio #(
        .NUM_BANKS (NUM_BANKS),
        .IDX_W     (IDX_W)
    ) u_prio (
        .scale    (scale),
        .hit_wide (hit_wide),
        .hit_lo   (hit_lo),
        .hit_hi   (hit_hi),
        .any_hit  (any_hit),
        .win_idx  (win_idx)
    );

    // Register the decision one cycle after the header strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_index  <= '0;
        end else begin
            res_valid <= hdr_valid;
            if (hdr_valid) begin
                res_accept <= any_hit;
                res_index  <= any_hit ? win_idx : '0;
            end
        end
    end

    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> res_valid);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !res_valid);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> ($stable(res_accept) && $stable(res_index)));

    // R6
    accept_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && (active == '0)) |=> !res_accept);

    // R8
    index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept |-> (int'(res_index) < NFILT));

endmodule

// File: tb/can_acc_filter_tb.sv
module can_acc_filter_tb;

    localparam int NB     = 14;
    localparam int ADDR_W = 5;
    localparam int IDX_W  = 5;
    localparam int SCALE_A  = 2 * NB;
    localparam int ACTIVE_A = 2 * NB + 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_init, cfg_we;
    logic [ADDR_W-1:0] cfg_addr;
    logic [31:0]       cfg_wdata;
    logic              hdr_valid;
    logic [28:0]       hdr_id;
    logic              hdr_ide, hdr_rtr;
    logic              res_valid, res_accept;
    logic [IDX_W-1:0]  res_index;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    can_acc_filter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_init   (cfg_init),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .hdr_valid  (hdr_valid),
        .hdr_id     (hdr_id),
        .hdr_ide    (hdr_ide),
        .hdr_rtr    (hdr_rtr),
        .res_valid  (res_valid),
        .res_accept (res_accept),
        .res_index  (res_index)
    );

    typedef struct packed {
        logic [28:0] id;
        logic        ide;
        logic        rtr;
        logic        acc;
        logic [4:0]  idx;
    } vec_t;

    // Filter words for the base setup
    localparam logic [31:0] B0_W1 = (32'h1ABCDE0 << 3) | 32'h4;
    localparam logic [31:0] B0_W2 = (32'h1FFFFFFF << 3) | 32'h4;
    localparam logic [31:0] B1_W1 = {16'hFFF8, 16'(11'h123 << 5)};
    localparam logic [31:0] B1_W2 = {16'((11'h7F0 << 5) | 16'h8), 16'(11'h7F0 << 5)};
    localparam logic [31:0] B2_W1 = 32'h4;
    localparam logic [31:0] B2_W2 = 32'h4;
    localparam logic [31:0] B3_W1 = {16'hFFFF, 16'h0000};
    localparam logic [31:0] B3_W2 = {16'h0018, 16'h0010};
    localparam logic [31:0] B4_W1 = {16'hFFF8, 16'(11'h055 << 5)};
    localparam logic [31:0] B4_W2 = {16'hFFFF, 16'h0000};

    // Wide banks 0,2 -> idx 0,1; narrow bank1 -> 2,3; bank3 -> 4,5; bank4 -> 6,7
    localparam vec_t VECS [12] = '{
        '{29'h1ABCDE0, 1'b1, 1'b0, 1'b1, 5'd0}, // R9 bank0 beats bank2
        '{29'h1ABCDE1, 1'b1, 1'b0, 1'b1, 5'd1}, // R10 IDE-only mask
        '{29'h1ABCDE0, 1'b1, 1'b1, 1'b1, 5'd0}, // R10 RTR don't-care
        '{29'h0000123, 1'b0, 1'b0, 1'b1, 5'd2}, // R5 even half
        '{29'h0000123, 1'b0, 1'b1, 1'b1, 5'd5}, // R5 RTR mismatch, R8 bank3 odd
        '{29'h00007F5, 1'b0, 1'b0, 1'b1, 5'd3}, // R5 odd half, partial mask
        '{29'h000070F, 1'b0, 1'b0, 1'b0, 5'd0}, // R9 reject index 0
        '{29'h0000055, 1'b0, 1'b0, 1'b0, 5'd0}, // R6 inactive bank4
        '{29'h0000000, 1'b0, 1'b0, 1'b0, 5'd0}, // R7 closed 16-bit filter
        '{29'h00007FF, 1'b0, 1'b1, 1'b1, 5'd3}, // R9 idx3 beats idx5
        '{29'h0000124, 1'b0, 1'b0, 1'b0, 5'd0}, // R4 exact compare miss
        '{29'h0000000, 1'b1, 1'b0, 1'b1, 5'd1}  // R4 ext frame on wide bank2
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(logic [28:0] id, logic ide, logic rtr);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_id = id; hdr_ide = ide; hdr_rtr = rtr;
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic expect_res(string req, logic acc, logic [4:0] idx);
        chk(req, {31'd0, res_valid}, 32'd1);
        chk(req, {31'd0, res_accept}, {31'd0, acc});
        chk(req, {27'd0, res_index}, {27'd0, idx});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_init = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        hdr_valid = 1'b0; hdr_id = '0; hdr_ide = 1'b0; hdr_rtr = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state of outputs
        chk("R1", {29'd0, res_valid, res_accept, 1'b0}, 32'd0);
        chk("R1", {27'd0, res_index}, 32'd0);
        rst_n = 1'b1;
        send(29'h0, 1'b0, 1'b0);
        expect_res("R1", 1'b0, 5'd0);
        send(29'h1ABCDE0, 1'b1, 1'b0);
        expect_res("R1", 1'b0, 5'd0);

        // Base setup (R3)
        cfg_init = 1'b1;
        wr(0, B0_W1); wr(1, B0_W2);
        wr(2, B1_W1); wr(3, B1_W2);
        wr(4, B2_W1); wr(5, B2_W2);
        wr(6, B3_W1); wr(7, B3_W2);
        wr(8, B4_W1); wr(9, B4_W2);
        wr(ADDR_W'(SCALE_A), 32'h5);
        wr(ADDR_W'(ACTIVE_A), 32'hF);
        cfg_init = 1'b0;

        for (int i = 0; i < 12; i++) begin
            send(VECS[i].id, VECS[i].ide, VECS[i].rtr);
            expect_res($sformatf("R8 vector %0d", i), VECS[i].acc, VECS[i].idx);
        end

        // R2: result strobe drops and values hold
        send(29'h0000123, 1'b0, 1'b0);
        @(negedge clk);
        chk("R2", {31'd0, res_valid}, 32'd0);
        chk("R2", {26'd0, res_accept, res_index}, {26'd0, 1'b1, 5'd2});

        // R3: writes with cfg_init low are ignored
        wr(0, 32'h0);
        wr(ADDR_W'(ACTIVE_A), 32'h0);
        send(29'h1ABCDE0, 1'b1, 1'b0);
        expect_res("R3", 1'b1, 5'd0);
        send(29'h0000123, 1'b0, 1'b0);
        expect_res("R3", 1'b1, 5'd2);

        // R6: deactivate bank0; numbering unchanged
        cfg_init = 1'b1;
        wr(ADDR_W'(ACTIVE_A), 32'hE);
        cfg_init = 1'b0;
        send(29'h1ABCDE0, 1'b1, 1'b0);
        expect_res("R6", 1'b1, 5'd1);
        send(29'h0000123, 1'b0, 1'b0);
        expect_res("R6", 1'b1, 5'd2);

        // R7: closed wide filter in bank2
        cfg_init = 1'b1;
        wr(4, 32'h0); wr(5, 32'hFFFF_FFFF);
        cfg_init = 1'b0;
        send(29'h0, 1'b0, 1'b0);
        expect_res("R7", 1'b0, 5'd0);
        send(29'h5, 1'b1, 1'b0);
        expect_res("R7", 1'b0, 5'd0);

        // R4: standard frame on a wide filter, RTR don't-care
        cfg_init = 1'b1;
        wr(4, 32'(11'h2AA) << 21); wr(5, (32'h7FF << 21) | 32'h4);
        cfg_init = 1'b0;
        send(29'h2AA, 1'b0, 1'b1);
        expect_res("R4", 1'b1, 5'd1);
        send(29'h2AB, 1'b0, 1'b0);
        expect_res("R4", 1'b0, 5'd0);

        // R5: extended frame on a narrow filter, bank4 odd half
        cfg_init = 1'b1;
        wr(9, {16'hFFFF, 16'h2AAD});
        wr(ADDR_W'(ACTIVE_A), 32'h1E);
        cfg_init = 1'b0;
        send(29'h5568000, 1'b1, 1'b0);
        expect_res("R5", 1'b1, 5'd7);
        send(29'h5560000, 1'b1, 1'b0);
        expect_res("R5", 1'b0, 5'd0);
        send(29'h0000055, 1'b0, 1'b0);
        expect_res("R8", 1'b1, 5'd6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule